// File: doc/BRIEF.md
# Dual 8-bit Period-Match Timer Pair

Two independent 8-bit up-counters. Each counter has its own period register. A counter climbs from zero until it equals its period. On the next advance it drops back to zero and raises its own sticky interrupt flag.

Each counter picks one of two count sources:
- an internal tick that fires once per instruction cycle, which is one clock in four;
- falling edges of an external clock pin that both counters share. The pin goes through a two-stage synchronizer and a falling-edge detector before it reaches the counters.

A run bit per counter stops or starts counting. A shared "wide mode" bit freezes both counters; cascaded operation belongs to another block.

Software reaches everything through a register-style port: one write port and one combinational read port. The interrupt output combines three things:
- each flag with its own enable;
- a peripheral enable, which must be set;
- a global disable, which must be clear.

Register map (3-bit address):

| Address | Contents |
|---|---|
| 0 | counter A |
| 1 | counter B |
| 2 | period A |
| 3 | period B |
| 4 | control |
| 5 | interrupt |

Control register bits: bit0 run A, bit1 run B, bit2 external-source A, bit3 external-source B, bit4 wide mode.

Interrupt register bits: bit0 flag A, bit1 flag B, bit2 enable A, bit3 enable B, bit4 peripheral enable, bit5 global disable.

Unused read bits and unmapped addresses return 0.

Top module: `dual_period_timer`

## Requirements
- R1: While rst_n is low at a rising clock edge, the following are set: both counters to 00h, both periods to FFh, control bits to 0, and interrupt register bits to 0. As a result, irq is 0.
- R2: With the run bit set and the source bit 0, a counter advances once every 4 clock cycles. The first advance after reset comes at the 4th rising edge after reset is released.
- R3: With the source bit 1, a counter advances once per falling edge of ext_clk_pin. The pin must hold each level for at least 3 cycles. The count changes at the third rising edge at which the pin is sampled low, after being sampled high.
- R4: A counter counts 0, 1, … up to its period value. On the next advance it becomes 00h and its flag becomes 1.
- R5: With a period of 00h, every advance keeps the counter at 00h and sets its flag.
- R6: With the run bit 0, a counter neither advances nor sets its flag.
- R7: With wide mode (control bit4) set, neither counter advances, whatever its run or source bits. Writes to the counters still take effect.
- R8: Flags are sticky. Writing 0 to a flag bit at address 5 clears it, and writing 1 has no effect. A wrap in the same cycle as a clearing write leaves the flag at 1.
- R9: A write to a counter's address replaces its value in that cycle, even when an advance would have happened. An advance blocked this way does not set the flag.
- R10: irq is 1 exactly when all of the following hold: the peripheral enable (bit4) is 1, the global disable (bit5) is 0, and at least one flag has its enable bit set.
- R11: Every register reads back at its address with the bit layout listed above. Reads are combinational from rd_addr.
- R12: The two counters keep separate periods, sources and flags. One may count pin edges while the other counts internal ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data for rd_addr |
| ext_clk_pin | input | 1 | Shared external count clock, asynchronous |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit width, a tick divide of 4 and two synchronizer stages. With these values, a period of 5 wraps within about 24 clocks, so many wraps and interrupt-flag collisions fit in a short run. A period of zero wraps on every tick. The pin is held 3 or 4 cycles per level, just above the minimum that two synchronizer stages allow. The edge-to-count latency is therefore checked at the tightest legal rate.

// File: rtl/dpt_pkg.sv
// Shared constants for the dual period-match timer.
// Assumes exactly two timer channels and an 8-bit-or-wider data path.
package dpt_pkg;
    localparam int NUM_TMR = 2;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] ADR_CNT0 = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CNT1 = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_PER0 = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_PER1 = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_IRQ  = 3'd5;

    // control register bit positions
    localparam int CTL_RUN_LSB = 0;
    localparam int CTL_SEL_LSB = 2;
    localparam int CTL_WIDE    = 4;

    // interrupt register bit positions
    localparam int IRQ_FLAG_LSB = 0;
    localparam int IRQ_IE_LSB   = 2;
    localparam int IRQ_PE       = 4;
    localparam int IRQ_GD       = 5;
endpackage

// File: rtl/dpt_tick_gen.sv
// Internal count tick: a one-cycle pulse every DIV clocks.
// Assumes DIV >= 2. The first pulse comes DIV cycles after reset.
module dpt_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = $clog2(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] phase_q;

    // free-running phase counter, wraps at LAST
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign tick = (phase_q == LAST);
endmodule

// File: rtl/dpt_edge_sync.sv
// Brings an asynchronous pin into the clock domain through STAGES flops,
// then gives a one-cycle pulse for each high-to-low transition.
// Assumes the pin holds each level for more than STAGES clock cycles.
module dpt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [STAGES:0] shr_q;

    // synchronizer chain plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            shr_q <= '0;
        else
            shr_q <= {shr_q[STAGES-1:0], pin};
    end

    assign fall = shr_q[STAGES] & ~shr_q[STAGES-1];
endmodule

// File: rtl/dpt_channel.sv
// One period-match channel: counter, period register and sticky flag.
// Assumes the tick and edge inputs are single-cycle pulses in the clk domain.
// A counter write beats an advance, and a wrap beats a flag-clear write.
module dpt_channel #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         hold_all,
    input  logic         sel_ext,
    input  logic         tick,
    input  logic         ext_fall,
    input  logic         cnt_we,
    input  logic         per_we,
    input  logic [W-1:0] wdata,
    input  logic         flag_we,
    input  logic         flag_wval,
    output logic [W-1:0] cnt,
    output logic [W-1:0] per,
    output logic         flag
);
    logic adv;
    logic hit;
    logic wrap;

    assign adv  = run & ~hold_all & (sel_ext ? ext_fall : tick);
    assign hit  = (cnt == per);
    assign wrap = adv & hit & ~cnt_we;

    // counter: software load first, then advance or wrap to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt_we)
            cnt <= wdata;
        else if (adv)
            cnt <= hit ? '0 : cnt + 1'b1;
    end

    // period register, resets to all ones
    always_ff @(posedge clk) begin
        if (!rst_n)
            per <= '1;
        else if (per_we)
            per <= wdata;
    end

    // sticky flag: set by wrap, cleared only by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else
            flag <= wrap | (flag_we ? (flag & flag_wval) : flag);
    end
endmodule

// File: rtl/dual_period_timer.sv
// Two 8-bit period-match timers with a shared synchronized external clock,
// a register port and a gated interrupt output.
// Assumes the external pin meets the synchronizer's minimum level time.
module dual_period_timer
    import dpt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int TICK_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [2:0]        rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              ext_clk_pin,
    output logic              irq
);
    logic                          tick;
    logic                          ext_fall;
    logic [NUM_TMR-1:0]            run_q;
    logic [NUM_TMR-1:0]            sel_q;
    logic                          wide_q;
    logic [NUM_TMR-1:0]            ie_q;
    logic                          pe_q;
    logic                          gd_q;
    logic [NUM_TMR-1:0]            flag_q;
    logic [NUM_TMR-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_TMR-1:0][CNT_W-1:0] per_q;
    logic                          ctrl_we;
    logic                          irq_we;

    assign ctrl_we = wr_en && (wr_addr == ADR_CTRL);
    assign irq_we  = wr_en && (wr_addr == ADR_IRQ);

    dpt_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    dpt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_clk_pin),
        .fall (ext_fall)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_ch
        localparam logic [2:0] CA = 3'(ADR_CNT0 + g);
        localparam logic [2:0] PA = 3'(ADR_PER0 + g);
        dpt_channel #(.W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q[g]),
            .hold_all (wide_q),
            .sel_ext  (sel_q[g]),
            .tick     (tick),
            .ext_fall (ext_fall),
            .cnt_we   (wr_en && (wr_addr == CA)),
            .per_we   (wr_en && (wr_addr == PA)),
            .wdata    (wr_data),
            .flag_we  (irq_we),
            .flag_wval(wr_data[IRQ_FLAG_LSB+g]),
            .cnt      (cnt_q[g]),
            .per      (per_q[g]),
            .flag     (flag_q[g])
        );
    end

    // control register: run, source select and wide-mode hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            sel_q  <= '0;
            wide_q <= 1'b0;
        end else if (ctrl_we) begin
            run_q  <= wr_data[CTL_RUN_LSB +: NUM_TMR];
            sel_q  <= wr_data[CTL_SEL_LSB +: NUM_TMR];
            wide_q <= wr_data[CTL_WIDE];
        end
    end

    // interrupt enables and gating bits (flags live in the channels)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= '0;
            pe_q <= 1'b0;
            gd_q <= 1'b0;
        end else if (irq_we) begin
            ie_q <= wr_data[IRQ_IE_LSB +: NUM_TMR];
            pe_q <= wr_data[IRQ_PE];
            gd_q <= wr_data[IRQ_GD];
        end
    end

    // combinational read mux
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CNT0: rd_data = cnt_q[0];
            ADR_CNT1: rd_data = cnt_q[1];
            ADR_PER0: rd_data = per_q[0];
            ADR_PER1: rd_data = per_q[1];
            ADR_CTRL: begin
                rd_data[CTL_RUN_LSB +: NUM_TMR] = run_q;
                rd_data[CTL_SEL_LSB +: NUM_TMR] = sel_q;
                rd_data[CTL_WIDE]               = wide_q;
            end
            ADR_IRQ: begin
                rd_data[IRQ_FLAG_LSB +: NUM_TMR] = flag_q;
                rd_data[IRQ_IE_LSB +: NUM_TMR]   = ie_q;
                rd_data[IRQ_PE]                  = pe_q;
                rd_data[IRQ_GD]                  = gd_q;
            end
            default: rd_data = '0;
        endcase
    end

    assign irq = pe_q & ~gd_q & |(flag_q & ie_q);
endmodule

// File: rtl/dpt_checker.sv
// Temporal checks on the dual period-match timer, bound to its top module.
module dpt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic             irq,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cnt1,
    input logic [1:0]       flags,
    input logic [1:0]       run,
    input logic             wide,
    input logic             pe,
    input logic             gd
);
    import dpt_pkg::*;

    // R6
    run_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[0] && !(wr_en && wr_addr == ADR_CNT0)) |=> $stable(cnt0));

    // R6
    run_off_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[0] && !flags[0]) |=> !flags[0]);

    // R7
    wide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !(wr_en && wr_addr == ADR_CNT1)) |=> $stable(cnt1));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !(wr_en && wr_addr == ADR_IRQ)) |=> flags[1]);

    // R4
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt0 != '0 && !(wr_en && wr_addr == ADR_CNT0)) |=> (cnt0 == '0 |-> flags[0]));

    // R10
    pe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pe |-> !irq);

    // R10
    gd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gd |-> !irq);
endmodule

bind dual_period_timer dpt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .irq    (irq),
    .cnt0   (cnt_q[0]),
    .cnt1   (cnt_q[1]),
    .flags  (flag_q),
    .run    (run_q),
    .wide   (wide_q),
    .pe     (pe_q),
    .gd     (gd_q)
);

// File: tb/dual_period_timer_tb.sv
`timescale 1ns/1ps
module dual_period_timer_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_clk_pin = 1'b1;
    logic       irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    dual_period_timer #(.CNT_W(8), .TICK_DIV(DIV), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_clk_pin(ext_clk_pin), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    int m_cnt[2] = '{0, 0};
    int m_per[2] = '{255, 255};
    bit m_run[2], m_sel[2], m_flag[2], m_ie[2];
    bit m_wide, m_pe, m_gd;
    int m_phase = 0;
    bit pin_hist[$] = '{0, 0, 0};
    bit t_tick, t_fall, t_adv, t_cw, t_wrap;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '{0, 0}; m_per = '{255, 255};
            m_run = '{0, 0}; m_sel = '{0, 0}; m_flag = '{0, 0}; m_ie = '{0, 0};
            m_wide = 0; m_pe = 0; m_gd = 0; m_phase = 0;
            pin_hist = '{0, 0, 0};
        end else begin
            t_tick = (m_phase == DIV - 1);
            t_fall = pin_hist[2] && !pin_hist[1];
            for (int i = 0; i < 2; i++) begin
                t_adv  = m_run[i] && !m_wide && (m_sel[i] ? t_fall : t_tick);
                t_cw   = wr_en && (wr_addr == 3'(i));
                t_wrap = t_adv && !t_cw && (m_cnt[i] == m_per[i]);
                if (t_cw) m_cnt[i] = wr_data;
                else if (t_adv) m_cnt[i] = (m_cnt[i] == m_per[i]) ? 0 : m_cnt[i] + 1;
                if (wr_en && wr_addr == 3'd5)
                    m_flag[i] = t_wrap || (m_flag[i] && wr_data[i]);
                else
                    m_flag[i] = t_wrap || m_flag[i];
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd2: m_per[0] = wr_data;
                    3'd3: m_per[1] = wr_data;
                    3'd4: begin
                        m_run[0] = wr_data[0]; m_run[1] = wr_data[1];
                        m_sel[0] = wr_data[2]; m_sel[1] = wr_data[3];
                        m_wide = wr_data[4];
                    end
                    3'd5: begin
                        m_ie[0] = wr_data[2]; m_ie[1] = wr_data[3];
                        m_pe = wr_data[4]; m_gd = wr_data[5];
                    end
                    default: ;
                endcase
            end
            m_phase = (m_phase + 1) % DIV;
            pin_hist.push_front(ext_clk_pin);
            void'(pin_hist.pop_back());
        end
    end

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return 8'(m_cnt[0]);
            3'd1: return 8'(m_cnt[1]);
            3'd2: return 8'(m_per[0]);
            3'd3: return 8'(m_per[1]);
            3'd4: return {3'b0, m_wide, m_sel[1], m_sel[0], m_run[1], m_run[0]};
            3'd5: return {2'b0, m_gd, m_pe, m_ie[1], m_ie[0], m_flag[1], m_flag[0]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit model_irq();
        return m_pe && !m_gd && ((m_flag[0] && m_ie[0]) || (m_flag[1] && m_ie[1]));
    endfunction

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        #1;
        checks++;
        if (rd_data !== model_read(rd_addr)) begin
            fails++;
            $display("FAIL %s addr %0d rd_data actual %02h expected %02h at cycle %0d",
                     tag, rd_addr, rd_data, model_read(rd_addr), cyc);
        end
        checks++;
        if (irq !== model_irq()) begin
            fails++;
            $display("FAIL %s irq actual %0b expected %0b at cycle %0d",
                     tag, irq, model_irq(), cyc);
        end
    end

    // rotate the read address so every register is observed
    always @(negedge clk) rd_addr <= (rd_addr == 3'd5) ? 3'd0 : rd_addr + 3'd1;

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_hold(input logic [2:0] a, input logic [7:0] d, input int n);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        repeat (n) @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pin_edges(input int n, input int hold);
        repeat (n) begin
            @(negedge clk) ext_clk_pin = 1'b0;
            idle(hold - 1);
            @(negedge clk) ext_clk_pin = 1'b1;
            idle(hold - 1);
        end
    endtask

    initial begin
        // R1: reset values
        tag = "R1";
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(8);
        // R11: register readback
        tag = "R11";
        wr(3'd2, 8'h5a); wr(3'd3, 8'h33); wr(3'd0, 8'h12); wr(3'd1, 8'h34);
        idle(12);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        // R2: internal tick rate, then R4: wrap at period
        wr(3'd2, 8'd5);
        tag = "R2";
        wr(3'd4, 8'h01);
        idle(12);
        tag = "R4";
        idle(40);
        // R10: interrupt gating
        tag = "R10";
        wr(3'd5, 8'h17); idle(8);
        wr(3'd5, 8'h37); idle(6);
        wr(3'd5, 8'h07); idle(4);
        wr(3'd5, 8'h17); idle(4);
        // R5: zero period, R8: clear collides with wraps
        tag = "R8";
        wr(3'd5, 8'h14); idle(2);
        tag = "R5";
        wr(3'd2, 8'h00); idle(12);
        tag = "R8";
        wr_hold(3'd5, 8'h14, 12); idle(4);
        // R9: counter write beats advance
        tag = "R9";
        wr_hold(3'd0, 8'h03, 10); idle(6);
        // R6: stopped counter
        tag = "R6";
        wr(3'd4, 8'h00); wr(3'd5, 8'h14); idle(16);
        // R3: external source on channel B
        tag = "R3";
        wr(3'd3, 8'd7); wr(3'd4, 8'h0a);
        pin_edges(10, 3);
        // R12: A external, B internal
        tag = "R12";
        wr(3'd2, 8'd4); wr(3'd4, 8'h07);
        pin_edges(8, 4);
        // R7: wide mode freezes both counters
        tag = "R7";
        wr(3'd4, 8'h17);
        pin_edges(4, 3);
        idle(10);
        wr(3'd0, 8'h09); idle(4);
        wr(3'd4, 8'h07); idle(10);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule